// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block turns a stream of stereo PCM words into a three-wire serial audio link: a bit clock, a word-select line and a serial data line. The bit clock that drives the block is passed straight out as the link's bit clock. Word-select and data are launched on its falling edge, so a receiver can sample them on the rising edge. Each frame has a left slot and then a right slot. Each slot is `WIDTH` bit clocks long, which makes the bit clock `2 × WIDTH` times the sample rate. Words go out MSB first.

Words arrive one channel at a time on a valid/ready handshake, and each word carries a left/right tag. A single holding register takes the word for the slot that comes next. A word whose tag does not name that slot is not accepted. If the next slot starts while the holding register is empty, the slot goes out as zeros and the underrun flag is high for that slot. Two inputs set the framing and the word-select polarity at run time. Both are meant to be changed only while reset is asserted.

Top module: `pcm_serial_tx`

## Requirements
- R1: `bclk_o` equals `clk`. Word-select holds each level for exactly `WIDTH` bit clocks, so one frame lasts `2*WIDTH` bit clocks.
- R2: With `fmt_i2s` = 0 (left-justified), a word's MSB is on `sd_o` in the same bit period in which word-select takes the level of its slot. The other bits follow MSB first.
- R3: With `fmt_i2s` = 1 (I2S), every data bit is one bit period later than in R2. The bit period in which word-select changes carries the LSB of the word before.
- R4: With `ws_invert` = 0, a low `ws_o` marks the left slot. With `ws_invert` = 1, a low `ws_o` marks the right slot.
- R5: `ws_o` and `sd_o` change only on the falling edge of `clk`. They stay steady while `clk` is high.
- R6: A word is taken at the falling edge when `in_valid` and `in_ready` are both high. Accepted words appear on the link in the order they were accepted, with their tagged channel and value.
- R7: `in_left` = 1 tags a left word and 0 tags a right word. `in_ready` is low whenever the tag does not name the slot after the current one.
- R8: The holding register has one entry. `in_ready` is low from the edge that fills it until the slot that consumes it begins. `in_ready` is also low during the last bit period of every slot.
- R9: A slot that begins with the holding register empty carries all zeros. `underrun` is high for exactly that whole slot.
- R10: While `rst` is high, `in_ready`, `underrun` and `sd_o` are low. The first slot after reset is a left slot and reports underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; the block works on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| fmt_i2s | input | 1 | Framing: 0 left-justified, 1 I2S |
| ws_invert | input | 1 | Word-select polarity: 0 low is left, 1 low is right |
| in_valid | input | 1 | Input word valid |
| in_left | input | 1 | Channel tag: 1 left, 0 right |
| in_data | input | WIDTH | Channel word |
| in_ready | output | 1 | Block can take the offered word |
| bclk_o | output | 1 | Forwarded bit clock |
| ws_o | output | 1 | Word-select |
| sd_o | output | 1 | Serial data, MSB first |
| underrun | output | 1 | Current slot went unfed |

## Verification
The stream is run in all four combinations of framing and polarity. The words include all-ones, alternating bits, single set MSB/LSB patterns and pseudo-random values. An off-by-one bit position, a swapped channel or a wrong polarity therefore corrupts a compared word. Each run first leaves the opening slot unfed, and later leaves a gap of two frames with nothing offered. This separates zero-filled underrun slots from real words and shows that ordering survives the gap. Offering the wrong tag, and offering a second word while the holding register is full, shows that readiness follows the tag and the single entry.

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fmt_i2s,
  input  logic             ws_invert,
  input  logic             in_valid,
  input  logic             in_left,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  output logic             bclk_o,
  output logic             ws_o,
  output logic             sd_o,
  output logic             underrun
);
  localparam int FRAME = 2 * WIDTH;
  localparam int CW = $clog2(FRAME);
  localparam logic [CW-1:0] LAST = CW'(FRAME - 1);
  localparam logic [CW-1:0] HALF = CW'(WIDTH);
  localparam logic [CW-1:0] HALF_LAST = CW'(WIDTH - 1);

  logic [CW-1:0]    pos_q, pos_nx;
  logic [WIDTH-1:0] shift_q, hold_q;
  logic             hold_full, prev_bit_q, ws_q, ur_q;
  logic             cur_right, slot_end, take;

  assign cur_right = pos_q >= HALF;
  assign slot_end  = (pos_q == LAST) || (pos_q == HALF_LAST);
  assign pos_nx    = (pos_q == LAST) ? '0 : pos_q + CW'(1);
  assign in_ready  = ~rst & ~hold_full & ~slot_end & (in_left == cur_right);
  assign take      = in_valid & in_ready;

  always_ff @(negedge clk) begin
    if (rst) begin
      pos_q      <= LAST;
      shift_q    <= '0;
      hold_q     <= '0;
      hold_full  <= 1'b0;
      prev_bit_q <= 1'b0;
      ws_q       <= ~ws_invert;
      ur_q       <= 1'b0;
    end else begin
      pos_q      <= pos_nx;
      prev_bit_q <= shift_q[WIDTH-1];
      ws_q       <= (pos_nx >= HALF) ^ ws_invert;
      if (slot_end) begin
        shift_q   <= hold_full ? hold_q : '0;
        ur_q      <= ~hold_full;
        hold_full <= 1'b0;
      end else begin
        shift_q <= shift_q << 1;
        if (take) begin
          hold_full <= 1'b1;
          hold_q    <= in_data;
        end
      end
    end
  end

  assign bclk_o   = clk;
  assign ws_o     = ws_q;
  assign sd_o     = fmt_i2s ? prev_bit_q : shift_q[WIDTH-1];
  assign underrun = ur_q;
endmodule

// File: rtl/pcm_serial_tx_chk.sv
module pcm_serial_tx_chk #(
  parameter int WIDTH = 16
) (
  input logic clk,
  input logic rst,
  input logic fmt_i2s,
  input logic ws_invert,
  input logic in_valid,
  input logic in_left,
  input logic in_ready,
  input logic ws_o,
  input logic sd_o,
  input logic underrun
);
  logic [15:0] run_q;
  logic        seen_q, last_ws_q;

  always_ff @(negedge clk) begin
    if (rst) begin
      run_q     <= '0;
      seen_q    <= 1'b0;
      last_ws_q <= ws_o;
    end else begin
      last_ws_q <= ws_o;
      if (ws_o != last_ws_q) begin
        run_q  <= '0;
        seen_q <= 1'b1;
      end else begin
        run_q <= run_q + 16'd1;
      end
    end
  end

  AST_SLOT_LENGTH: assert property (@(negedge clk) disable iff (rst)
    (seen_q && ws_o != last_ws_q) |-> (32'(run_q) == WIDTH - 1)); // R1
  AST_TAG_MATCH: assert property (@(negedge clk) disable iff (rst)
    (in_valid && in_ready) |-> (in_left != (ws_o == ws_invert))); // R7
  AST_SINGLE_ENTRY: assert property (@(negedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready); // R8
  AST_UNDERRUN_ZERO: assert property (@(negedge clk) disable iff (rst)
    (underrun && !fmt_i2s) |-> !sd_o); // R9
  AST_RESET_NOT_READY: assert property (@(negedge clk)
    rst |-> !in_ready); // R10
endmodule

bind pcm_serial_tx pcm_serial_tx_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .fmt_i2s(fmt_i2s), .ws_invert(ws_invert),
  .in_valid(in_valid), .in_left(in_left), .in_ready(in_ready),
  .ws_o(ws_o), .sd_o(sd_o), .underrun(underrun)
);

// File: tb/pcm_serial_tx_tb_top.sv
module pcm_serial_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  typedef struct packed { logic l; logic [W-1:0] d; } item_t;

  logic clk = 1'b0, rst = 1'b1, fmt_i2s = 1'b0, ws_invert = 1'b0;
  logic in_valid = 1'b0, in_left = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, bclk_o, ws_o, sd_o, underrun;

  int checks = 0, fails = 0, ur_cnt = 0;
  item_t exp_q[$];
  bit mon_en = 0, m_prev, m_seen, m_have, m_chan, m_ur, m_ur0;
  int m_pos;
  logic [W-1:0] m_acc;

  pcm_serial_tx #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .fmt_i2s(fmt_i2s), .ws_invert(ws_invert),
    .in_valid(in_valid), .in_left(in_left), .in_data(in_data),
    .in_ready(in_ready), .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o),
    .underrun(underrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_word(bit chan, bit ur, logic [W-1:0] data);
    item_t it;
    if (ur) begin
      ur_cnt++;
      chk(data == '0, "R9", "underrun slot data", data, 0);
    end else if (exp_q.size() == 0) begin
      chk(0, "R6", "word with nothing queued", data, 0);
    end else begin
      it = exp_q.pop_front();
      chk(it.l == chan, fmt_i2s ? "R3 R4" : "R2 R4", "channel", chan, it.l);
      chk(it.d == data, fmt_i2s ? "R3 R6" : "R2 R6", "word", data, it.d);
    end
  endtask

  always @(posedge clk) begin
    if (mon_en) begin
      if (ws_o != m_prev) begin
        if (m_seen) chk(m_pos == W - 1, "R1", "slot length", m_pos + 1, W);
        m_seen = 1;
        m_pos = 0;
        m_ur0 = underrun;
      end else m_pos++;
      m_prev = ws_o;
      if (m_pos == W - 1) chk(underrun == m_ur0, "R9", "flag steady", underrun, m_ur0);
      if (!fmt_i2s) begin
        m_acc = {m_acc[W-2:0], sd_o};
        if (m_pos == W - 1) finish_word(ws_o == ws_invert, underrun, m_acc);
      end else if (m_pos == 0) begin
        if (m_have) begin
          m_acc = {m_acc[W-2:0], sd_o};
          finish_word(m_chan, m_ur, m_acc);
        end
        m_have = 0;
      end else begin
        m_acc = {m_acc[W-2:0], sd_o};
        if (m_pos == W - 1) begin
          m_chan = (ws_o == ws_invert);
          m_ur = underrun;
          m_have = 1;
        end
      end
    end
  end

  always @(posedge clk) begin
    if (mon_en) begin : stab
      logic a, b;
      #1 a = ws_o; b = sd_o;
      #(CLK_PERIOD/2 - 2);
      chk(ws_o == a && sd_o == b && bclk_o == 1'b1, "R5", "steady while clock high",
          {bclk_o, ws_o, sd_o}, {1'b1, a, b});
    end
  end

  task automatic send(bit l, logic [W-1:0] d);
    bit acc;
    in_left = l;
    in_data = d;
    do begin
      @(posedge clk); #1;
      in_valid = 1'b1;
      acc = in_ready;
      if (acc) exp_q.push_back('{l: l, d: d});
      @(negedge clk); #1;
      in_valid = 1'b0;
    end while (!acc);
  endtask

  function automatic logic [W-1:0] pattern(int k);
    case (k % 5)
      0: return {W{1'b1}};
      1: return {(W/2){2'b10}};
      2: return {1'b1, {(W-2){1'b0}}, 1'b1};
      3: return W'(k * 16'h1357 + 1);
      default: return W'($urandom);
    endcase
  endfunction

  task automatic run_mode(bit fmt, bit inv);
    rst = 1'b1;
    mon_en = 0;
    fmt_i2s = fmt;
    ws_invert = inv;
    repeat (3) @(posedge clk);
    #1;
    chk(!in_ready && !underrun && !sd_o, "R10", "outputs in reset",
        {in_ready, underrun, sd_o}, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    exp_q.delete();
    m_prev = ws_o; m_seen = 0; m_have = 0; m_pos = 0; m_acc = '0;
    ur_cnt = 0;
    mon_en = 1;
    @(posedge clk); #1;
    chk(ws_o == inv && underrun, "R10", "first slot left and unfed", {ws_o, underrun}, {inv, 1'b1});
    in_left = 1'b1;
    #1 chk(!in_ready, "R7", "left tag refused during left slot", in_ready, 0);
    in_left = 1'b0;
    #1 chk(in_ready, "R7", "right tag taken during left slot", in_ready, 1);
    send(1'b0, pattern(0));
    chk(!in_ready, "R8", "second word refused while holding", in_ready, 0);
    send(1'b1, pattern(1));
    for (int k = 1; k < 4; k++) begin
      send(1'b0, pattern(2 * k));
      send(1'b1, pattern(2 * k + 1));
    end
    repeat (4 * W) @(posedge clk);
    for (int k = 4; k < 8; k++) begin
      send(1'b0, pattern(2 * k));
      send(1'b1, pattern(2 * k + 1));
    end
    repeat (6 * W) @(posedge clk);
    #1;
    chk(exp_q.size() == 0, "R6", "all accepted words sent", exp_q.size(), 0);
    chk(ur_cnt >= 3, "R9", "unfed slots flagged", ur_cnt, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "watchdog", "run hung", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    run_mode(1'b0, 1'b0);
    run_mode(1'b1, 1'b1);
    run_mode(1'b1, 1'b0);
    run_mode(1'b0, 1'b1);
    mon_en = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule